// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps an asynchronous DRAM refreshed on behalf of an access controller. An interval timer produces one refresh obligation every fixed number of clock cycles. The obligations are held in a saturating backlog counter, so refreshes missed while the controller is busy can later be worked off in a burst. While the backlog is non-zero the block raises an urgent flag, and the controller answers with a grant once it has closed its open row.

On a grant the block runs one refresh in which column strobe falls ahead of row strobe. Column strobe goes low first, with row strobe still high. Row strobe then follows it low for a programmed pulse width. Both strobes then return high for a programmed precharge time. Write enable stays high throughout. No address is driven, because the memory takes the row from its own internal counter. At the end of each refresh the block pulses a done output, and the backlog drops by one. With an 8 ns clock, the default interval of 1950 cycles gives the usual average of about 15.6 µs. That average holds for both 8192 rows in 128 ms and 4096 rows in 64 ms. The default pulse widths exceed a 50 ns row-strobe low time and a 30 ns precharge.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is active and after it: ras_n, cas_n and we_n are 1, and backlog, rfsh_urgent, rfsh_busy and rfsh_done are 0.
- R2: After reset is released, backlog rises by one every INTERVAL_CYC cycles. Reset restarts the interval, and the first increment follows one full interval.
- R3: backlog never exceeds BACKLOG_MAX. A timer expiry that finds the backlog full is discarded, unless a refresh completes in the same cycle.
- R4: rfsh_urgent is 1 exactly when backlog is non-zero.
- R5: A refresh starts only when bus_grant is 1, no refresh is running and backlog is non-zero. A grant at any other time has no effect on the strobes.
- R6: cas_n falls CAS_LEAD_CYC cycles before ras_n falls. ras_n is 1 while cas_n falls, and ras_n is never 0 while cas_n is 1.
- R7: ras_n and cas_n stay 0 together for RAS_LOW_CYC cycles. Both are then 1 for RAS_PRE_CYC cycles before rfsh_busy drops.
- R8: we_n is 1 at all times.
- R9: rfsh_done is a one-cycle pulse in the cycle after the precharge ends, and backlog falls by one at that same edge. A timer expiry in the same cycle leaves backlog unchanged.
- R10: A refresh that has started runs to completion whatever bus_grant does.
- R11: Between two refreshes, at least one idle cycle separates the end of precharge from the next fall of cas_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_grant | input | 1 | Access controller hands the memory bus to the refresh block |
| rfsh_urgent | output | 1 | At least one refresh is owed |
| rfsh_busy | output | 1 | A refresh sequence is in progress |
| rfsh_done | output | 1 | One-cycle pulse on completion of a refresh |
| backlog | output | $clog2(BACKLOG_MAX+1) | Number of refreshes owed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
The case hardest to reach from the ports is a timer expiry that lands exactly when a refresh completes while the backlog is full. That is the only case in which an expiry at saturation is not discarded. A short bench interval lets the backlog fill while the grant is withheld. A long stretch of pseudo-random grant toggling then shifts refresh completions across many timer phases, and the reference model checks the backlog on every cycle. Dropping the grant in mid-sequence, and granting with nothing owed, cover R10 and R5.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LEAD = 2'd1,
    SEQ_ACT  = 2'd2,
    SEQ_PRE  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/rfsh_tick_timer.sv
module rfsh_tick_timer #(
  parameter int INTERVAL_CYC = 1950
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = $clog2(INTERVAL_CYC);
  localparam logic [W-1:0] RELOAD = W'(INTERVAL_CYC - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign tick   = (cnt_q == '0);
  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      if (tick) cnt_d = RELOAD;
      else      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int BACKLOG_MAX = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               tick,
  input  logic                               take,
  output logic [$clog2(BACKLOG_MAX+1)-1:0]   count,
  output logic                               nonzero
);
  localparam int W = $clog2(BACKLOG_MAX + 1);
  localparam logic [W-1:0] FULL = W'(BACKLOG_MAX);

  logic [W-1:0] cnt_q, cnt_d;
  logic         add, sub, cnt_en;

  assign add    = tick && ((cnt_q != FULL) || take);
  assign sub    = take && (cnt_q != '0);
  assign cnt_en = add ^ sub;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      if (add) cnt_d = cnt_q + 1'b1;
      else     cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count   = cnt_q;
  assign nonzero = (cnt_q != '0);
endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
  import rfsh_pkg::*;
#(
  parameter int CAS_LEAD_CYC = 1,
  parameter int RAS_LOW_CYC  = 7,
  parameter int RAS_PRE_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic owed,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic finish,
  output logic done
);
  localparam int PH_MAX0 = (CAS_LEAD_CYC > RAS_LOW_CYC) ? CAS_LEAD_CYC : RAS_LOW_CYC;
  localparam int PH_MAX  = (PH_MAX0 > RAS_PRE_CYC) ? PH_MAX0 : RAS_PRE_CYC;
  localparam int W       = $clog2(PH_MAX + 1);
  localparam logic [W-1:0] LEAD_LAST = W'(CAS_LEAD_CYC - 1);
  localparam logic [W-1:0] LOW_LAST  = W'(RAS_LOW_CYC - 1);
  localparam logic [W-1:0] PRE_LAST  = W'(RAS_PRE_CYC - 1);

  seq_state_t   st_q, st_d;
  logic [W-1:0] ph_q, ph_d;
  logic         ras_n_q, cas_n_q, done_q;
  logic         ph_end;

  always_comb begin
    case (st_q)
      SEQ_LEAD: ph_end = (ph_q == LEAD_LAST);
      SEQ_ACT:  ph_end = (ph_q == LOW_LAST);
      SEQ_PRE:  ph_end = (ph_q == PRE_LAST);
      default:  ph_end = 1'b0;
    endcase
  end

  assign finish = (st_q == SEQ_PRE) && ph_end;

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    case (st_q)
      SEQ_IDLE: begin
        if (grant && owed) begin
          st_d = SEQ_LEAD;
          ph_d = '0;
        end
      end
      SEQ_LEAD: begin
        if (ph_end) begin st_d = SEQ_ACT; ph_d = '0; end
        else        ph_d = ph_q + 1'b1;
      end
      SEQ_ACT: begin
        if (ph_end) begin st_d = SEQ_PRE; ph_d = '0; end
        else        ph_d = ph_q + 1'b1;
      end
      default: begin
        if (ph_end) begin st_d = SEQ_IDLE; ph_d = '0; end
        else        ph_d = ph_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      ph_q    <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      ras_n_q <= (st_d != SEQ_ACT);
      cas_n_q <= !((st_d == SEQ_LEAD) || (st_d == SEQ_ACT));
      done_q  <= finish;
    end
  end

  assign ras_n = ras_n_q;
  assign cas_n = cas_n_q;
  assign busy  = (st_q != SEQ_IDLE);
  assign done  = done_q;
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int INTERVAL_CYC = 1950,
  parameter int BACKLOG_MAX  = 8,
  parameter int CAS_LEAD_CYC = 1,
  parameter int RAS_LOW_CYC  = 7,
  parameter int RAS_PRE_CYC  = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_grant,
  output logic                             rfsh_urgent,
  output logic                             rfsh_busy,
  output logic                             rfsh_done,
  output logic [$clog2(BACKLOG_MAX+1)-1:0] backlog,
  output logic                             ras_n,
  output logic                             cas_n,
  output logic                             we_n
);
  logic sync1_q, sync2_q, rst_int_n;
  logic tick, finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end
  assign rst_int_n = sync2_q;

  rfsh_tick_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_int_n),
    .tick (tick)
  );

  rfsh_backlog #(.BACKLOG_MAX(BACKLOG_MAX)) u_backlog (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick   (tick),
    .take   (finish),
    .count  (backlog),
    .nonzero(rfsh_urgent)
  );

  rfsh_strobe_seq #(
    .CAS_LEAD_CYC(CAS_LEAD_CYC),
    .RAS_LOW_CYC (RAS_LOW_CYC),
    .RAS_PRE_CYC (RAS_PRE_CYC)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .grant (bus_grant),
    .owed  (rfsh_urgent),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .busy  (rfsh_busy),
    .finish(finish),
    .done  (rfsh_done)
  );

  assign we_n = 1'b1;
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int BACKLOG_MAX = 8
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             bus_grant,
  input logic                             rfsh_urgent,
  input logic                             rfsh_busy,
  input logic                             rfsh_done,
  input logic [$clog2(BACKLOG_MAX+1)-1:0] backlog,
  input logic                             ras_n,
  input logic                             cas_n,
  input logic                             we_n
);
  p_we_high_r8: assert property (@(posedge clk) disable iff (!rst_n) we_n);

  p_ras_with_cas_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

  p_cas_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));

  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    backlog <= BACKLOG_MAX);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_done |=> !rfsh_done);

  p_done_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_done |-> backlog <= $past(backlog));

  p_start_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_busy) |-> ($past(bus_grant) && $past(rfsh_urgent)));

  p_urgent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_busy) |-> $past(backlog) != 0);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_done |-> (!rfsh_busy && ras_n && cas_n));
endmodule

bind rfsh_sched rfsh_sched_chk #(.BACKLOG_MAX(BACKLOG_MAX)) u_chk (.*);

// File: tb/rfsh_sched_test.sv
module rfsh_sched_test;
  localparam int IVL  = 40;
  localparam int MAXB = 4;
  localparam int LEAD = 1;
  localparam int LOW  = 3;
  localparam int PRE  = 2;
  localparam int CW   = $clog2(MAXB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_grant = 1'b0;
  logic rfsh_urgent, rfsh_busy, rfsh_done, ras_n, cas_n, we_n;
  logic [CW-1:0] backlog;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rfsh_sched #(
    .INTERVAL_CYC(IVL), .BACKLOG_MAX(MAXB),
    .CAS_LEAD_CYC(LEAD), .RAS_LOW_CYC(LOW), .RAS_PRE_CYC(PRE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant),
    .rfsh_urgent(rfsh_urgent), .rfsh_busy(rfsh_busy), .rfsh_done(rfsh_done),
    .backlog(backlog), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  // behavioural reference: phase 0 idle, 1 cas lead, 2 ras low, 3 precharge
  int m_wait = 0, m_until_tick = IVL, m_owed = 0, m_phase = 0, m_left = 0;
  bit m_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wait = 0; m_until_tick = IVL; m_owed = 0; m_phase = 0; m_left = 0; m_done = 0;
    end else if (m_wait < 2) begin
      m_wait++;
    end else begin
      bit ends, expire;
      ends   = (m_phase == 3) && (m_left == 1);
      m_until_tick--;
      expire = (m_until_tick == 0);
      if (expire) m_until_tick = IVL;
      if (expire && (m_owed < MAXB || ends)) m_owed++;
      if (ends) m_owed--;
      if (m_phase == 0) begin
        if (bus_grant && m_owed - (expire ? 1 : 0) + (ends ? 1 : 0) > 0) begin
          m_phase = 1; m_left = LEAD;
        end
      end else begin
        m_left--;
        if (m_left == 0) begin
          case (m_phase)
            1: begin m_phase = 2; m_left = LOW; end
            2: begin m_phase = 3; m_left = PRE; end
            default: m_phase = 0;
          endcase
        end
      end
      m_done = ends;
    end
  end

  task automatic chk(string req, string sig, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, sig, act, exp, $time);
    end
  endtask

  bit prev_cas = 1'b1;
  bit prev2_cas = 1'b1;
  always @(negedge clk) begin
    chk("R2/R3/R9", "backlog", int'(backlog), m_owed);
    chk("R4", "rfsh_urgent", int'(rfsh_urgent), int'(m_owed != 0));
    chk("R5/R10", "rfsh_busy", int'(rfsh_busy), int'(m_phase != 0));
    chk("R6", "cas_n", int'(cas_n), int'(!(m_phase == 1 || m_phase == 2)));
    chk("R7", "ras_n", int'(ras_n), int'(m_phase != 2));
    chk("R8", "we_n", int'(we_n), 1);
    chk("R9", "rfsh_done", int'(rfsh_done), int'(m_done));
    // R11: a fresh cas_n fall needs an idle cycle before it
    if (prev_cas && !cas_n) chk("R11", "cas_n_idle_gap", int'(prev2_cas), 1);
    prev2_cas = prev_cas;
    prev_cas  = cas_n;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(3);
    // R1: outputs during reset
    chk("R1", "ras_n", int'(ras_n), 1);
    chk("R1", "cas_n", int'(cas_n), 1);
    chk("R1", "backlog", int'(backlog), 0);
    chk("R1", "rfsh_busy", int'(rfsh_busy), 0);
    rst_n = 1'b1;
    // R2, R3: no grant, backlog fills and saturates
    cyc(IVL * (MAXB + 2));
    chk("R3", "backlog_saturated", int'(backlog), MAXB);
    // R11, R9: grant held, burst works the backlog off
    bus_grant = 1'b1;
    cyc(60);
    // R5: grant with nothing owed leaves strobes idle
    cyc(5);
    bus_grant = 1'b0;
    cyc(IVL);
    // R10: one-cycle grant, sequence must run to completion
    bus_grant = 1'b1;
    cyc(1);
    bus_grant = 1'b0;
    cyc(1);
    chk("R10", "busy_after_drop", int'(rfsh_busy), 1);
    cyc(LEAD + LOW + PRE + 3);
    // let backlog fill, then random grants to hit tick/finish collisions at full
    cyc(IVL * (MAXB + 1));
    for (int i = 0; i < 3000; i++) begin
      bus_grant = ($urandom_range(0, 7) == 0);
      cyc(1);
    end
    bus_grant = 1'b0;
    // R1: reset in mid-run
    cyc(17);
    rst_n = 1'b0;
    cyc(1);
    chk("R1", "backlog_in_reset", int'(backlog), 0);
    chk("R1", "rfsh_urgent_in_reset", int'(rfsh_urgent), 0);
    cyc(2);
    rst_n = 1'b1;
    cyc(IVL + 10);
    bus_grant = 1'b1;
    cyc(30);
    bus_grant = 1'b0;
    cyc(10);
    summary();
  end
endmodule